// File: doc/BRIEF.md
# Nibble-Wide Addressed Bus Device Port

This block is the device end of a shared parallel bus that a network node uses to reach several small peripheral controllers over a handful of pins. Data crosses the bus four bits at a time, with one group of lines from the node to the devices and a separate group from the devices to the node. The node owns the direction line (`bus_rw`) and the strobe (`bus_cs`). Each device answers every accepted nibble with its own acknowledge (`bus_hs`). A wired busy line, which the node never sees, lets devices take turns when the node reads.

A fall on the direction line opens a packet, and every device listens to the first byte. That byte is an 8-bit address made of three subfields: location in bits 7:6, device type in bits 5:2 and instance in bits 1:0. The device goes on only if all three match its strap. If they match, it takes in a length byte, up to 16 body bytes and a checksum byte. It keeps the body in a small buffer that the local application reads by index. If the checksum is good, the device can later answer the node's read with a response packet in the same layout.

Controller states are `ST_IDLE`, `ST_RX_ADDR`, `ST_RX_LEN`, `ST_RX_BODY`, `ST_RX_SUM`, `ST_IGNORE`, `ST_RSP_WAIT`, `ST_TX_ADDR`, `ST_TX_LEN`, `ST_TX_BODY` and `ST_TX_SUM`. A packet start moves any state to `ST_RX_ADDR`. The transitions are:
- From `ST_RX_ADDR`: to `ST_RX_LEN` on an address match, otherwise to `ST_IGNORE`.
- From `ST_RX_LEN`: to `ST_RX_BODY`, or to `ST_RX_SUM` when the length is 0, or to `ST_IGNORE` when the length is too large.
- From `ST_RX_BODY`: to `ST_RX_SUM` after the last body byte.
- From `ST_RX_SUM`: to `ST_RSP_WAIT` on a good checksum, otherwise to `ST_IDLE`.
- From `ST_RSP_WAIT`: to `ST_TX_ADDR` once the node reads and the busy line is free.
- Transmit: `ST_TX_ADDR`, then `ST_TX_LEN`, then `ST_TX_BODY` (skipped when the response length is 0), then `ST_TX_SUM`, then back to `ST_IDLE`.

Top module: `nibble_bus_dev`

## Requirements
- R1: Each byte crosses the bus as two nibbles, high nibble first, in both directions. A nibble transfer is `bus_cs` rising, the device raising `bus_hs`, `bus_cs` falling, and the device dropping `bus_hs`. While `bus_hs` is high on a read, `bus_dout` holds steady.
- R2: A high-to-low transition on `bus_rw` starts a new packet in any state, including partway through a packet. It clears `pkt_ok` and `pkt_err`, and the next byte is treated as an address.
- R3: The device acknowledges both address nibbles. It keeps acknowledging only when the whole 8-bit address equals `my_addr`. On any mismatch, including one in the 2-bit instance field alone, it raises no `bus_hs` and leaves `pkt_ok` low until the next packet start.
- R4: The checksum byte must equal the modulo-256 sum of the address, length and body bytes. If it does, `pkt_ok` goes high, `pkt_len` shows the body length, and `rd_data` returns body byte `rd_idx`, counting from 0.
- R5: If the checksum does not match, `pkt_err` goes high and `pkt_ok` stays low. The two flags are never high together.
- R6: A length byte above 16 raises `pkt_err`, and the device stops acknowledging until the next packet start.
- R7: A length of 0 is followed directly by the checksum byte.
- R8: After a good packet, while `bus_rw` is high and `busy_in` is low, the device answers reads with `my_addr`, the response length, body bytes `rsp_byte` for `rsp_idx` 0 upward, and then the modulo-256 sum of all of these. `busy_out` stays high from the start of the response until its last nibble.
- R9: While `busy_in` is high, a device waiting to respond stays silent: it keeps `busy_out` low and raises no `bus_hs`.
- R10: After reset, `bus_hs`, `busy_out`, `pkt_ok` and `pkt_err` are all low.
- R11: A `rsp_len` above 16 is sent as 16, and exactly 16 body bytes follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| my_addr | input | 8 | Address strap: location[7:6], type[5:2], instance[1:0] |
| bus_rw | input | 1 | Direction line from the node; low means the node writes |
| bus_cs | input | 1 | Node strobe |
| bus_din | input | 4 | Nibble from node to device |
| bus_dout | output | 4 | Nibble from device to node |
| bus_hs | output | 1 | Device acknowledge |
| busy_in | input | 1 | Wired busy line as driven by the other devices |
| busy_out | output | 1 | This device's drive of the busy line |
| pkt_ok | output | 1 | Last packet addressed here passed its checksum |
| pkt_err | output | 1 | Last packet addressed here had a bad checksum or length |
| pkt_len | output | 5 | Body length of the last good packet |
| rd_idx | input | 4 | Body buffer read index |
| rd_data | output | 8 | Body byte at `rd_idx` |
| rsp_len | input | 5 | Response body length from the application |
| rsp_idx | output | 4 | Index of the response body byte being requested |
| rsp_byte | input | 8 | Response body byte for `rsp_idx` |

## Verification
The hardest case to reach from the ports is a packet abandoned partway: its address and length have already been taken, and then the node pulls `bus_rw` low again. The device must drop the half-built checksum and restart on the new address. The bench builds this case directly, then sends a complete good packet and expects the flags and the buffer to reflect only that packet. The response path is also hard to reach. It requires a good packet, then a read with the busy line held high, and only then a release of the busy line. The bench holds `busy_in` high first, probes with a strobe to confirm the device stays silent, and then releases it. Random packets with varied lengths, including the 0 and 16 ends, and occasional corrupted checksums cover the main receive path.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_ADDR,
        ST_RX_LEN,
        ST_RX_BODY,
        ST_RX_SUM,
        ST_IGNORE,
        ST_RSP_WAIT,
        ST_TX_ADDR,
        ST_TX_LEN,
        ST_TX_BODY,
        ST_TX_SUM
    } dev_state_t;
endpackage

// File: rtl/nbd_link.sv
// Nibble handshake engine: packet-start detection, byte assembly on writes,
// nibble presentation on reads.
module nbd_link #(
    parameter int NW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rw,
    input  logic            cs,
    input  logic [NW-1:0]   din,
    input  logic            listen,
    input  logic            talk,
    input  logic [2*NW-1:0] tx_byte,
    output logic            start,
    output logic            byte_valid,
    output logic [2*NW-1:0] rx_byte,
    output logic            byte_taken,
    output logic            hs,
    output logic [NW-1:0]   dout
);
    logic          rw_q, cs_q, hi_phase, hs_q;
    logic [NW-1:0] hi_nib, dout_q;
    logic          cs_rise, cs_fall;

    assign cs_rise = cs & ~cs_q;
    assign cs_fall = ~cs & cs_q;
    assign start   = rw_q & ~rw;
    assign hs      = hs_q;
    assign dout    = dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q       <= 1'b1;
            cs_q       <= 1'b0;
            hi_phase   <= 1'b1;
            hs_q       <= 1'b0;
            hi_nib     <= '0;
            dout_q     <= '0;
            rx_byte    <= '0;
            byte_valid <= 1'b0;
            byte_taken <= 1'b0;
        end else begin
            rw_q       <= rw;
            cs_q       <= cs;
            byte_valid <= 1'b0;
            byte_taken <= 1'b0;
            if (start) begin
                hi_phase <= 1'b1;
                hs_q     <= 1'b0;
            end else if (cs_rise && !rw && listen) begin
                hs_q <= 1'b1;
                if (hi_phase) begin
                    hi_nib   <= din;
                    hi_phase <= 1'b0;
                end else begin
                    rx_byte    <= {hi_nib, din};
                    byte_valid <= 1'b1;
                    hi_phase   <= 1'b1;
                end
            end else if (cs_rise && rw && talk) begin
                hs_q   <= 1'b1;
                dout_q <= hi_phase ? tx_byte[2*NW-1:NW] : tx_byte[NW-1:0];
            end else if (cs_fall && hs_q) begin
                hs_q <= 1'b0;
                if (rw && talk) begin
                    if (hi_phase) begin
                        hi_phase <= 1'b0;
                    end else begin
                        hi_phase   <= 1'b1;
                        byte_taken <= 1'b1;
                    end
                end
            end
        end
    end

    // R1: a presented read nibble is held for the whole acknowledge
    a_r1_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q && $past(hs_q) && rw) |-> $stable(dout_q));
endmodule

// File: rtl/nbd_store.sv
module nbd_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/nbd_ctrl.sv
module nbd_ctrl
    import nbd_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int BW      = 8,
    localparam int LW     = $clog2(MAX_LEN + 1),
    localparam int IW     = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] my_addr,
    input  logic          start,
    input  logic          byte_valid,
    input  logic [BW-1:0] rx_byte,
    input  logic          byte_taken,
    input  logic          rw,
    input  logic          busy_in,
    input  logic [LW-1:0] rsp_len,
    input  logic [BW-1:0] rsp_byte,
    output logic          listen,
    output logic          talk,
    output logic          busy,
    output logic [BW-1:0] tx_byte,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [BW-1:0] wr_data,
    output logic [IW-1:0] rsp_idx,
    output logic          pkt_ok,
    output logic          pkt_err,
    output logic [LW-1:0] pkt_len
);
    localparam logic [BW-1:0] MAX_B = BW'(MAX_LEN);
    localparam logic [LW-1:0] MAX_L = LW'(MAX_LEN);
    localparam logic [LW-1:0] ONE_L = LW'(1);

    dev_state_t    state, nxt;
    logic [BW-1:0] sum;
    logic [LW-1:0] len, idx, rlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_RX_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: nxt = state;
                ST_RX_ADDR:
                    if (byte_valid) nxt = (rx_byte == my_addr) ? ST_RX_LEN : ST_IGNORE;
                ST_RX_LEN:
                    if (byte_valid) begin
                        if (rx_byte > MAX_B)          nxt = ST_IGNORE;
                        else if (rx_byte == '0)       nxt = ST_RX_SUM;
                        else                          nxt = ST_RX_BODY;
                    end
                ST_RX_BODY:
                    if (byte_valid && idx == len - ONE_L) nxt = ST_RX_SUM;
                ST_RX_SUM:
                    if (byte_valid) nxt = (rx_byte == sum) ? ST_RSP_WAIT : ST_IDLE;
                ST_RSP_WAIT:
                    if (rw && !busy_in) nxt = ST_TX_ADDR;
                ST_TX_ADDR:
                    if (byte_taken) nxt = ST_TX_LEN;
                ST_TX_LEN:
                    if (byte_taken) nxt = (rlen == '0) ? ST_TX_SUM : ST_TX_BODY;
                ST_TX_BODY:
                    if (byte_taken && idx == rlen - ONE_L) nxt = ST_TX_SUM;
                ST_TX_SUM:
                    if (byte_taken) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        listen  = 1'b0;
        talk    = 1'b0;
        tx_byte = '0;
        wr_en   = 1'b0;
        unique case (state)
            ST_RX_ADDR, ST_RX_LEN, ST_RX_SUM: listen = 1'b1;
            ST_RX_BODY: begin
                listen = 1'b1;
                wr_en  = byte_valid && !start;
            end
            ST_TX_ADDR: begin talk = 1'b1; tx_byte = my_addr; end
            ST_TX_LEN:  begin talk = 1'b1; tx_byte = {{(BW-LW){1'b0}}, rlen}; end
            ST_TX_BODY: begin talk = 1'b1; tx_byte = rsp_byte; end
            ST_TX_SUM:  begin talk = 1'b1; tx_byte = sum; end
            default: ;
        endcase
    end

    assign busy    = talk;
    assign wr_idx  = idx[IW-1:0];
    assign wr_data = rx_byte;
    assign rsp_idx = idx[IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum     <= '0;
            len     <= '0;
            idx     <= '0;
            rlen    <= '0;
            pkt_ok  <= 1'b0;
            pkt_err <= 1'b0;
            pkt_len <= '0;
        end else if (start) begin
            pkt_ok  <= 1'b0;
            pkt_err <= 1'b0;
            idx     <= '0;
        end else if (state == ST_RSP_WAIT) begin
            if (rw && !busy_in) begin
                sum  <= '0;
                idx  <= '0;
                rlen <= (rsp_len > MAX_L) ? MAX_L : rsp_len;
            end
        end else if (byte_valid && listen) begin
            sum <= sum + rx_byte;
            if (state == ST_RX_ADDR) sum <= rx_byte;
            if (state == ST_RX_LEN) begin
                len <= rx_byte[LW-1:0];
                idx <= '0;
                if (rx_byte > MAX_B) pkt_err <= 1'b1;
            end
            if (state == ST_RX_BODY) idx <= idx + ONE_L;
            if (state == ST_RX_SUM) begin
                if (rx_byte == sum) begin
                    pkt_ok  <= 1'b1;
                    pkt_len <= len;
                end else begin
                    pkt_err <= 1'b1;
                end
            end
        end else if (byte_taken && talk) begin
            sum <= sum + tx_byte;
            if (state == ST_TX_BODY) idx <= idx + ONE_L;
        end
    end

    // R2: a packet start always lands in the address phase
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && $past(rst_n)) |-> (state == ST_RX_ADDR && !pkt_ok && !pkt_err));
    // R3: a device that dropped out never acknowledges data
    a_r3_quiet_when_out: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !(listen || talk));
endmodule

// File: rtl/nibble_bus_dev.sv
module nibble_bus_dev #(
    parameter int NW      = 4,
    parameter int MAX_LEN = 16,
    localparam int BW     = 2 * NW,
    localparam int LW     = $clog2(MAX_LEN + 1),
    localparam int IW     = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] my_addr,
    input  logic          bus_rw,
    input  logic          bus_cs,
    input  logic [NW-1:0] bus_din,
    output logic [NW-1:0] bus_dout,
    output logic          bus_hs,
    input  logic          busy_in,
    output logic          busy_out,
    output logic          pkt_ok,
    output logic          pkt_err,
    output logic [LW-1:0] pkt_len,
    input  logic [IW-1:0] rd_idx,
    output logic [BW-1:0] rd_data,
    input  logic [LW-1:0] rsp_len,
    output logic [IW-1:0] rsp_idx,
    input  logic [BW-1:0] rsp_byte
);
    logic          start, byte_valid, byte_taken, listen, talk, wr_en;
    logic [BW-1:0] rx_byte, tx_byte, wr_data;
    logic [IW-1:0] wr_idx;

    nbd_link #(.NW(NW)) u_link (
        .clk(clk), .rst_n(rst_n), .rw(bus_rw), .cs(bus_cs), .din(bus_din),
        .listen(listen), .talk(talk), .tx_byte(tx_byte), .start(start),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .byte_taken(byte_taken),
        .hs(bus_hs), .dout(bus_dout)
    );

    nbd_ctrl #(.MAX_LEN(MAX_LEN), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .start(start),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .byte_taken(byte_taken),
        .rw(bus_rw), .busy_in(busy_in), .rsp_len(rsp_len), .rsp_byte(rsp_byte),
        .listen(listen), .talk(talk), .busy(busy_out), .tx_byte(tx_byte),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rsp_idx(rsp_idx),
        .pkt_ok(pkt_ok), .pkt_err(pkt_err), .pkt_len(pkt_len)
    );

    nbd_store #(.DEPTH(MAX_LEN), .W(BW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // R5: good and bad outcomes are exclusive
    a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_ok && pkt_err));
    // R4: a reported length never exceeds the buffer
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok |-> (pkt_len <= LW'(MAX_LEN)));
    // R8: the device only claims the busy line after a good packet
    a_r8_busy_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out |-> pkt_ok);
    // R9: no response starts while another device holds the busy line
    a_r9_defer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_out) |-> !$past(busy_in));
endmodule

// File: tb/nibble_bus_dev_bench.sv
module nibble_bus_dev_bench;
    localparam logic [7:0] ADDR = 8'b10_0110_01;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_rw = 1'b1, bus_cs = 1'b0, busy_in = 1'b0;
    logic [3:0] bus_din = '0, bus_dout, rd_idx = '0, rsp_idx;
    logic       bus_hs, busy_out, pkt_ok, pkt_err;
    logic [4:0] pkt_len, rsp_len = '0;
    logic [7:0] rd_data, rsp_byte;

    int n_chk = 0, n_bad = 0;
    logic [7:0] body [16];

    always #5 clk = ~clk;

    function automatic logic [7:0] rsp_val(input logic [3:0] i);
        return 8'(i) * 8'd13 + 8'h5A;
    endfunction
    assign rsp_byte = rsp_val(rsp_idx);

    nibble_bus_dev u_nibble_bus_dev (
        .clk(clk), .rst_n(rst_n), .my_addr(ADDR), .bus_rw(bus_rw), .bus_cs(bus_cs),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_hs(bus_hs), .busy_in(busy_in),
        .busy_out(busy_out), .pkt_ok(pkt_ok), .pkt_err(pkt_err), .pkt_len(pkt_len),
        .rd_idx(rd_idx), .rd_data(rd_data), .rsp_len(rsp_len), .rsp_idx(rsp_idx),
        .rsp_byte(rsp_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_nib(input logic [3:0] n, output logic ack);
        bus_din = n; bus_cs = 1'b1;
        repeat (4) @(negedge clk);
        ack = bus_hs;
        bus_cs = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic a1, a2;
        wr_nib(b[7:4], a1);
        wr_nib(b[3:0], a2);
        ack = a1 & a2;
    endtask

    task automatic rd_byte(output logic [7:0] b, output logic ack, output logic busy);
        logic a1;
        bus_cs = 1'b1; repeat (4) @(negedge clk);
        b[7:4] = bus_dout; a1 = bus_hs; busy = busy_out;
        bus_cs = 1'b0; repeat (4) @(negedge clk);
        bus_cs = 1'b1; repeat (4) @(negedge clk);
        b[3:0] = bus_dout; ack = a1 & bus_hs; busy = busy & busy_out;
        bus_cs = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic pkt_start();
        bus_rw = 1'b1; repeat (2) @(negedge clk);
        bus_rw = 1'b0; repeat (2) @(negedge clk);
    endtask

    // sends a full packet; returns AND of all acknowledges
    task automatic send_pkt(input logic [7:0] a, input logic [7:0] ln, input int nb,
                            input logic corrupt, output logic ack);
        logic [7:0] s;
        logic a1;
        pkt_start();
        ack = 1'b1;
        s = a + ln;
        wr_byte(a, a1);  ack &= a1;
        wr_byte(ln, a1); ack &= a1;
        for (int i = 0; i < nb; i++) begin
            s += body[i];
            wr_byte(body[i], a1); ack &= a1;
        end
        wr_byte(corrupt ? s ^ 8'h01 : s, a1); ack &= a1;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_body(input int nb, input string tag);
        for (int i = 0; i < nb; i++) begin
            rd_idx = 4'(i); #1;
            chk(tag, 32'(rd_data), 32'(body[i]));
        end
    endtask

    task automatic check_resp(input int expn, input string tag);
        logic [7:0] b, s;
        logic ack, bsy;
        rd_byte(b, ack, bsy);
        chk({tag, " addr"}, 32'(b), 32'(ADDR));
        chk({tag, " busy"}, 32'(bsy & ack), 32'd1);
        s = b;
        rd_byte(b, ack, bsy);
        chk({tag, " len"}, 32'(b), 32'(expn));
        s += b;
        for (int i = 0; i < expn; i++) begin
            rd_byte(b, ack, bsy);
            chk({tag, " body"}, 32'(b), 32'(rsp_val(4'(i))));
            s += b;
        end
        rd_byte(b, ack, bsy);
        chk({tag, " sum"}, 32'(b), 32'(s));
        chk({tag, " busy released"}, 32'(busy_out), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack, a1;
        logic [7:0] ln;
        logic cor;
        int nb;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk("R10 hs", 32'(bus_hs), 0);
        chk("R10 busy", 32'(busy_out), 0);
        chk("R10 ok", 32'(pkt_ok), 0);
        chk("R10 err", 32'(pkt_err), 0);

        // R1 R3 R4: directed good packet
        body[0] = 8'hA5; body[1] = 8'h3C; body[2] = 8'hF0;
        send_pkt(ADDR, 8'd3, 3, 1'b0, ack);
        chk("R1 R3 acks", 32'(ack), 1);
        chk("R4 ok", 32'(pkt_ok), 1);
        chk("R4 len", 32'(pkt_len), 3);
        check_body(3, "R4 body");

        // R4 R5 R7: random packets, lengths 0..16
        for (int k = 0; k < 24; k++) begin
            nb = (k == 0) ? 0 : (k == 1) ? 16 : int'($urandom_range(0, 16));
            for (int i = 0; i < nb; i++) body[i] = 8'($urandom());
            cor = ($urandom_range(0, 3) == 0);
            send_pkt(ADDR, 8'(nb), nb, cor, ack);
            chk("R7 R4 acks", 32'(ack), 1);
            chk(cor ? "R5 ok low" : "R4 ok", 32'(pkt_ok), cor ? 0 : 1);
            chk(cor ? "R5 err" : "R4 err low", 32'(pkt_err), cor ? 1 : 0);
            if (!cor) begin
                chk("R4 len", 32'(pkt_len), 32'(nb));
                check_body(nb, "R4 body");
            end
        end

        // R3: address differing only in instance field
        pkt_start();
        wr_byte(ADDR ^ 8'h01, ack);
        chk("R3 addr acked", 32'(ack), 1);
        wr_nib(4'h0, a1);
        chk("R3 no ack after mismatch", 32'(a1), 0);
        wr_nib(4'h1, a1); wr_byte(8'h00, a1); wr_byte(ADDR + 8'h01, a1);
        chk("R3 ok low", 32'(pkt_ok), 0);
        // R3: location field mismatch
        body[0] = 8'h11;
        send_pkt(ADDR ^ 8'h80, 8'd1, 1, 1'b0, ack);
        chk("R3 loc mismatch ok low", 32'(pkt_ok), 0);

        // R6: oversize length
        pkt_start();
        wr_byte(ADDR, a1);
        wr_byte(8'd17, a1);
        chk("R6 err", 32'(pkt_err), 1);
        wr_nib(4'h2, a1);
        chk("R6 no ack", 32'(a1), 0);

        // R2: restart partway through, then good packet
        pkt_start();
        wr_byte(ADDR, a1);
        wr_byte(8'd5, a1);
        wr_byte(8'h77, a1);
        body[0] = 8'hC3; body[1] = 8'h18;
        send_pkt(ADDR, 8'd2, 2, 1'b0, ack);
        chk("R2 acks", 32'(ack), 1);
        chk("R2 ok", 32'(pkt_ok), 1);
        chk("R2 len", 32'(pkt_len), 2);
        check_body(2, "R2 body");

        // R9 then R8: response deferred by busy line
        rsp_len = 5'd5;
        busy_in = 1'b1;
        bus_rw = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 busy low", 32'(busy_out), 0);
        bus_cs = 1'b1; repeat (4) @(negedge clk);
        chk("R9 no hs", 32'(bus_hs), 0);
        bus_cs = 1'b0; repeat (4) @(negedge clk);
        busy_in = 1'b0;
        repeat (3) @(negedge clk);
        check_resp(5, "R8");

        // R11: clipped response length
        body[0] = 8'h01;
        send_pkt(ADDR, 8'd1, 1, 1'b0, ack);
        chk("R11 ok", 32'(pkt_ok), 1);
        rsp_len = 5'd20;
        bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        check_resp(16, "R11");

        // R8: zero-length response
        send_pkt(ADDR, 8'd0, 0, 1'b0, ack);
        rsp_len = 5'd0;
        bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        check_resp(0, "R8 empty");

        // R5: bad packet gives no response
        body[0] = 8'h22;
        send_pkt(ADDR, 8'd1, 1, 1'b1, ack);
        bus_rw = 1'b1;
        repeat (3) @(negedge clk);
        bus_cs = 1'b1; repeat (4) @(negedge clk);
        chk("R5 no response", 32'(bus_hs | busy_out), 0);
        bus_cs = 1'b0; repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule